// File: doc/BRIEF.md
# Encoder Sleep and Power-Down Controller

This block decides which parts of a video encoder are powered and clocked. It takes configuration bits held by the serial control port, an asynchronous sleep pin and an active-low reset. From them it drives registered enables for the PLL, the crystal oscillator pad, the crystal buffer, the clock input and output buffers, the core clock, the general digital I/O pads, the alternate-address pad, each DAC and the voltage reference. One enable is combinational: the serial-port clock enable follows the raw sleep pin directly.

Two sleep levels exist. The software sleep bit stops the core and analog side but leaves the control port reachable. The sleep pin does the same and also cuts the control port and the alternate-address pad, so only releasing the pin ends it. A keep-alive bit holds the PLL up through either kind of sleep. Shutting down the crystal pad is latched: the oscillator stays off until reset, or until the core is switched to the external clock with the pad-disable bit cleared. The power-down bits for normal operation stay in force during sleep.

Top module: `enc_power_ctrl`

## Requirements
- R1: While reset is low, and directly after it, every registered enable (pllEn, xtalPadEn, xtalBufEn, clkOutEn, clkInEn, coreClkEn, ioPadEn, altAddrEn, each dacEn bit, vrefEn) is 1, and clkSrcExt and oscHeld are 0.
- R2: pllEn is 1 only when cfgPllOff is 0 and either no sleep is in force or cfgPllKeep is 1; cfgPllKeep has no effect while cfgPllOff is 1.
- R3: When cfgXtalPadOff is 1, xtalPadEn is 0 and oscHeld is 1 after the next rising edge, and xtalPadEn stays 0 while oscHeld is 1.
- R4: oscHeld clears only by reset or by an edge at which cfgUseExtClk is 1 and cfgXtalPadOff is 0; on that edge xtalPadEn returns to 1.
- R5: xtalBufEn, clkOutEn and clkInEn are the inverses of cfgXtalBufOff, cfgClkOutOff and cfgClkInOff, whatever the sleep state.
- R6: dacEn bit i is 1 only when cfgDacOff bit i, cfgAnalogOff and sleep are all 0; vrefEn is 1 only when cfgAnalogOff and sleep are 0; cfgAnalogOff does not change coreClkEn or ioPadEn.
- R7: With cfgSwSleep at 1, coreClkEn, ioPadEn, every dacEn bit and vrefEn are 0 after the next edge, while altAddrEn and spClkEn stay 1 if the pin is low.
- R8: A change on sleepPin reaches the registered enables on the third rising edge after it is applied (two synchronizer stages plus the output register); pin sleep has every effect of software sleep and also drives altAddrEn to 0, and ends only when the pin returns to 0.
- R9: spClkEn is the inverse of the raw sleepPin, with no clock delay.
- R10: clkSrcExt follows cfgUseExtClk one rising edge later.
- R11: Every configuration bit reaches its enables on the first rising edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepPin | input | 1 | Asynchronous sleep pin, 1 = sleep |
| cfgSwSleep | input | 1 | Software sleep request |
| cfgPllOff | input | 1 | Turn the PLL off |
| cfgPllKeep | input | 1 | Keep the PLL running through sleep |
| cfgXtalPadOff | input | 1 | Shut the crystal oscillator pad down (latched) |
| cfgUseExtClk | input | 1 | Core clock source: 1 = external clock input |
| cfgXtalBufOff | input | 1 | Disable the crystal buffer |
| cfgClkOutOff | input | 1 | Disable the clock output pad |
| cfgClkInOff | input | 1 | Disable the clock input buffer |
| cfgAnalogOff | input | 1 | Power down all DACs and the voltage reference |
| cfgDacOff | input | NUM_DAC | Per-DAC power-down bits |
| pllEn | output | 1 | PLL enable |
| xtalPadEn | output | 1 | Crystal oscillator pad enable |
| xtalBufEn | output | 1 | Crystal buffer enable |
| clkOutEn | output | 1 | Clock output pad enable |
| clkInEn | output | 1 | Clock input buffer enable |
| spClkEn | output | 1 | Serial-port clock enable (combinational) |
| coreClkEn | output | 1 | Internal core clock enable |
| ioPadEn | output | 1 | General digital I/O pad group enable |
| altAddrEn | output | 1 | Alternate-address pad enable |
| dacEn | output | NUM_DAC | Per-DAC power enable |
| vrefEn | output | 1 | Voltage reference enable |
| clkSrcExt | output | 1 | Registered clock source, 1 = external |
| oscHeld | output | 1 | Oscillator is latched off and needs recovery |

## Verification
A wrong oscillator latch shows at xtalPadEn and oscHeld on the first edge after the pad-disable bit or clock source changes, and a stuck latch only shows once the bench tries to recover through the external clock. A synchronizer that is one stage short or long shifts every sleep-driven enable by one cycle, which the bench sees by comparing each cycle against a model with exactly three edges of pin latency. Priority mistakes between keep-alive, PLL-off and the two sleep levels show at pllEn and altAddrEn in the same cycle the offending combination is registered.

// File: rtl/enc_power_pkg.sv
`timescale 1ns/1ps
package enc_power_pkg;
  // Strobes handed from the sleep control to the enable datapath.
  typedef struct packed {
    logic pinSleep;  // synchronized pin sleep
    logic anySleep;  // pin or software sleep
    logic oscKill;   // oscillator pad must be off after this edge
  } pwrStrobe_t;
endpackage

// File: rtl/enc_power_seq.sv
`timescale 1ns/1ps
module enc_power_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepPin,
  input  logic cfgSwSleep,
  input  logic cfgXtalPadOff,
  input  logic cfgUseExtClk,
  output enc_power_pkg::pwrStrobe_t strobe,
  output logic oscHeld
);
  import enc_power_pkg::*;

  logic [SYNC_STAGES-1:0] syncChain;
  logic pinSleepS;
  logic oscKill;

  // Synchronizer chain for the asynchronous pin.
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else if (s == 0) syncChain[s] <= sleepPin;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinSleepS = syncChain[SYNC_STAGES-1];

  // Oscillator-off latch: set by the pad-disable bit, released only by
  // reset or by moving to the external clock with the bit clear.
  assign oscKill = cfgXtalPadOff | (oscHeld & ~cfgUseExtClk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oscHeld <= 1'b0;
    else       oscHeld <= oscKill;
  end

  always_comb begin
    strobe.pinSleep = pinSleepS;
    strobe.anySleep = pinSleepS | cfgSwSleep;
    strobe.oscKill  = oscKill;
  end

  p_osc_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgXtalPadOff |=> oscHeld);

  p_osc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (oscHeld && !cfgUseExtClk) |=> oscHeld);

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncChain[0]) |=> pinSleepS);
endmodule

// File: rtl/enc_power_enables.sv
`timescale 1ns/1ps
module enc_power_enables #(
  parameter int NUM_DAC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  enc_power_pkg::pwrStrobe_t strobe,
  input  logic cfgPllOff,
  input  logic cfgPllKeep,
  input  logic cfgUseExtClk,
  input  logic cfgXtalBufOff,
  input  logic cfgClkOutOff,
  input  logic cfgClkInOff,
  input  logic cfgAnalogOff,
  input  logic [NUM_DAC-1:0] cfgDacOff,
  output logic pllEn,
  output logic xtalPadEn,
  output logic xtalBufEn,
  output logic clkOutEn,
  output logic clkInEn,
  output logic coreClkEn,
  output logic ioPadEn,
  output logic altAddrEn,
  output logic [NUM_DAC-1:0] dacEn,
  output logic vrefEn,
  output logic clkSrcExt
);
  import enc_power_pkg::*;

  logic analogOn;
  assign analogOn = ~cfgAnalogOff & ~strobe.anySleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllEn     <= 1'b1;
      xtalPadEn <= 1'b1;
      xtalBufEn <= 1'b1;
      clkOutEn  <= 1'b1;
      clkInEn   <= 1'b1;
      coreClkEn <= 1'b1;
      ioPadEn   <= 1'b1;
      altAddrEn <= 1'b1;
      vrefEn    <= 1'b1;
      clkSrcExt <= 1'b0;
    end else begin
      pllEn     <= ~cfgPllOff & (~strobe.anySleep | cfgPllKeep);
      xtalPadEn <= ~strobe.oscKill;
      xtalBufEn <= ~cfgXtalBufOff;
      clkOutEn  <= ~cfgClkOutOff;
      clkInEn   <= ~cfgClkInOff;
      coreClkEn <= ~strobe.anySleep;
      ioPadEn   <= ~strobe.anySleep;
      altAddrEn <= ~strobe.pinSleep;
      vrefEn    <= analogOn;
      clkSrcExt <= cfgUseExtClk;
    end
  end

  genvar d;
  generate
    for (d = 0; d < NUM_DAC; d++) begin : g_dac
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dacEn[d] <= 1'b1;
        else       dacEn[d] <= ~cfgDacOff[d] & analogOn;
      end
    end
  endgenerate

  p_pll_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgPllOff |=> !pllEn);

  p_analog_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgAnalogOff |=> (dacEn == '0 && !vrefEn));

  p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.anySleep |=> (!coreClkEn && !ioPadEn && dacEn == '0));

  p_pin_alt_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pinSleep |=> !altAddrEn);

  p_pad_latched_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.oscKill |=> !xtalPadEn);
endmodule

// File: rtl/enc_power_ctrl.sv
`timescale 1ns/1ps
module enc_power_ctrl #(
  parameter int NUM_DAC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepPin,
  input  logic cfgSwSleep,
  input  logic cfgPllOff,
  input  logic cfgPllKeep,
  input  logic cfgXtalPadOff,
  input  logic cfgUseExtClk,
  input  logic cfgXtalBufOff,
  input  logic cfgClkOutOff,
  input  logic cfgClkInOff,
  input  logic cfgAnalogOff,
  input  logic [NUM_DAC-1:0] cfgDacOff,
  output logic pllEn,
  output logic xtalPadEn,
  output logic xtalBufEn,
  output logic clkOutEn,
  output logic clkInEn,
  output logic spClkEn,
  output logic coreClkEn,
  output logic ioPadEn,
  output logic altAddrEn,
  output logic [NUM_DAC-1:0] dacEn,
  output logic vrefEn,
  output logic clkSrcExt,
  output logic oscHeld
);
  import enc_power_pkg::*;

  pwrStrobe_t strobe;

  // The serial port must die the moment the pin rises, so no register here.
  assign spClkEn = ~sleepPin;

  enc_power_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk(clk), .rstN(rstN), .sleepPin(sleepPin), .cfgSwSleep(cfgSwSleep),
    .cfgXtalPadOff(cfgXtalPadOff), .cfgUseExtClk(cfgUseExtClk),
    .strobe(strobe), .oscHeld(oscHeld)
  );

  enc_power_enables #(.NUM_DAC(NUM_DAC)) u_enables (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgPllOff(cfgPllOff), .cfgPllKeep(cfgPllKeep), .cfgUseExtClk(cfgUseExtClk),
    .cfgXtalBufOff(cfgXtalBufOff), .cfgClkOutOff(cfgClkOutOff),
    .cfgClkInOff(cfgClkInOff), .cfgAnalogOff(cfgAnalogOff), .cfgDacOff(cfgDacOff),
    .pllEn(pllEn), .xtalPadEn(xtalPadEn), .xtalBufEn(xtalBufEn),
    .clkOutEn(clkOutEn), .clkInEn(clkInEn), .coreClkEn(coreClkEn),
    .ioPadEn(ioPadEn), .altAddrEn(altAddrEn), .dacEn(dacEn), .vrefEn(vrefEn),
    .clkSrcExt(clkSrcExt)
  );

  p_keep_alive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPllKeep && !cfgPllOff) |=> pllEn);

  p_port_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgClkInOff |=> clkInEn);
endmodule

// File: tb/enc_power_ctrl_test.sv
`timescale 1ns/1ps
module enc_power_ctrl_test;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepPin = 1'b0;
  logic cfgSwSleep = 0, cfgPllOff = 0, cfgPllKeep = 0, cfgXtalPadOff = 0;
  logic cfgUseExtClk = 0, cfgXtalBufOff = 0, cfgClkOutOff = 0, cfgClkInOff = 0;
  logic cfgAnalogOff = 0;
  logic [N-1:0] cfgDacOff = '0;

  logic pllEn, xtalPadEn, xtalBufEn, clkOutEn, clkInEn, spClkEn, coreClkEn;
  logic ioPadEn, altAddrEn, vrefEn, clkSrcExt, oscHeld;
  logic [N-1:0] dacEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model state
  logic m1 = 0, m2 = 0, mHeld = 0;
  logic ePll = 1, ePad = 1, eCore = 1, eIo = 1, eAlt = 1, eVref = 1, eSrc = 0;
  logic [2:0] eBuf = 3'b111;
  logic [N-1:0] eDac = '1;

  enc_power_ctrl #(.NUM_DAC(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .sleepPin(sleepPin), .cfgSwSleep(cfgSwSleep),
    .cfgPllOff(cfgPllOff), .cfgPllKeep(cfgPllKeep), .cfgXtalPadOff(cfgXtalPadOff),
    .cfgUseExtClk(cfgUseExtClk), .cfgXtalBufOff(cfgXtalBufOff),
    .cfgClkOutOff(cfgClkOutOff), .cfgClkInOff(cfgClkInOff),
    .cfgAnalogOff(cfgAnalogOff), .cfgDacOff(cfgDacOff),
    .pllEn(pllEn), .xtalPadEn(xtalPadEn), .xtalBufEn(xtalBufEn),
    .clkOutEn(clkOutEn), .clkInEn(clkInEn), .spClkEn(spClkEn),
    .coreClkEn(coreClkEn), .ioPadEn(ioPadEn), .altAddrEn(altAddrEn),
    .dacEn(dacEn), .vrefEn(vrefEn), .clkSrcExt(clkSrcExt), .oscHeld(oscHeld)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pllExp(logic off, logic keep, logic sleep);
    return ~off & (~sleep | keep);
  endfunction

  task automatic modelReset();
    m1 = 0; m2 = 0; mHeld = 0;
    ePll = 1; ePad = 1; eCore = 1; eIo = 1; eAlt = 1; eVref = 1; eSrc = 0;
    eBuf = 3'b111; eDac = '1;
  endtask

  task automatic compareAll();
    check("R2 pllEn", {7'd0, pllEn}, {7'd0, ePll});
    check("R3 xtalPadEn", {7'd0, xtalPadEn}, {7'd0, ePad});
    check("R4 oscHeld", {7'd0, oscHeld}, {7'd0, mHeld});
    check("R5 buffers", {5'd0, xtalBufEn, clkOutEn, clkInEn}, {5'd0, eBuf});
    check("R6 dac/vref", {4'd0, dacEn, vrefEn}, {4'd0, eDac, eVref});
    check("R7 core/io", {6'd0, coreClkEn, ioPadEn}, {6'd0, eCore, eIo});
    check("R8 altAddrEn", {7'd0, altAddrEn}, {7'd0, eAlt});
    check("R9 spClkEn", {7'd0, spClkEn}, {7'd0, ~sleepPin});
    check("R10 clkSrcExt", {7'd0, clkSrcExt}, {7'd0, eSrc});
  endtask

  // Called at a negedge with inputs set; advances one edge (R11 latency).
  task automatic tick();
    logic any, kill;
    any  = cfgSwSleep | m2;
    kill = cfgXtalPadOff | (mHeld & ~cfgUseExtClk);
    ePll  = pllExp(cfgPllOff, cfgPllKeep, any);
    ePad  = ~kill;
    eBuf  = {~cfgXtalBufOff, ~cfgClkOutOff, ~cfgClkInOff};
    eDac  = ~cfgDacOff & {N{~cfgAnalogOff & ~any}};
    eVref = ~cfgAnalogOff & ~any;
    eCore = ~any;
    eIo   = ~any;
    eAlt  = ~m2;
    eSrc  = cfgUseExtClk;
    m2 = m1; m1 = sleepPin; mHeld = kill;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic clearCfg();
    cfgSwSleep = 0; cfgPllOff = 0; cfgPllKeep = 0; cfgXtalPadOff = 0;
    cfgUseExtClk = 0; cfgXtalBufOff = 0; cfgClkOutOff = 0; cfgClkInOff = 0;
    cfgAnalogOff = 0; cfgDacOff = '0; sleepPin = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    // R1: reset state, with config bits set to show reset wins
    cfgPllOff = 1; cfgAnalogOff = 1;
    repeat (2) @(negedge clk);
    modelReset();
    compareAll();
    check("R1 reset clkSrcExt", {7'd0, clkSrcExt}, 8'd0);
    clearCfg();
    rstN = 1;
    tick();
    check("R1 enables after reset", {7'd0, coreClkEn & pllEn & vrefEn & (&dacEn)}, 8'd1);

    // R3/R4: latch oscillator off, clear bit but stay on crystal
    cfgXtalPadOff = 1; tick();
    check("R3 pad off", {7'd0, xtalPadEn}, 8'd0);
    cfgXtalPadOff = 0; repeat (3) tick();
    check("R4 stays held", {7'd0, oscHeld}, 8'd1);
    cfgUseExtClk = 1; tick();
    check("R4 recovered via ext clock", {7'd0, xtalPadEn}, 8'd1);
    // R4: reset also clears the latch
    cfgUseExtClk = 0; cfgXtalPadOff = 1; tick(); cfgXtalPadOff = 0; tick();
    rstN = 0; #1; modelReset();
    check("R4 reset clears held", {7'd0, oscHeld}, 8'd0);
    @(negedge clk); rstN = 1; tick();

    // R8: pin latency: two edges still awake, third asleep
    sleepPin = 1; #1;
    check("R9 spClk falls at once", {7'd0, spClkEn}, 8'd0);
    tick(); check("R8 edge1 awake", {7'd0, coreClkEn}, 8'd1);
    tick(); check("R8 edge2 awake", {7'd0, coreClkEn}, 8'd1);
    tick(); check("R8 edge3 asleep", {7'd0, altAddrEn | coreClkEn}, 8'd0);
    // R2: keep-alive during pin sleep, overridden by PLL-off
    cfgPllKeep = 1; tick();
    check("R2 keep-alive", {7'd0, pllEn}, 8'd1);
    cfgPllOff = 1; tick();
    check("R2 pll-off beats keep", {7'd0, pllEn}, 8'd0);
    // R5: buffers follow bits during sleep
    cfgClkOutOff = 1; tick();
    check("R5 clkOut in sleep", {7'd0, clkOutEn}, 8'd0);
    sleepPin = 0; clearCfg(); repeat (3) tick();
    check("R8 wake", {7'd0, coreClkEn & altAddrEn}, 8'd1);

    // R7: software sleep keeps altAddr and serial port
    cfgSwSleep = 1; tick();
    check("R7 sw sleep alt on", {7'd0, altAddrEn & spClkEn}, 8'd1);
    check("R7 sw sleep core off", {7'd0, coreClkEn | vrefEn}, 8'd0);
    cfgSwSleep = 0;
    // R6: analog off leaves core running
    cfgAnalogOff = 1; tick();
    check("R6 analog off core on", {6'd0, coreClkEn, ioPadEn}, 8'd3);
    cfgAnalogOff = 0; cfgDacOff = 3'b010; tick();
    check("R6 single dac", {5'd0, dacEn}, 8'b101);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) sleepPin = ~sleepPin;
      cfgSwSleep    = (($urandom % 8) == 0);
      cfgPllOff     = $urandom;
      cfgPllKeep    = $urandom;
      cfgXtalPadOff = (($urandom % 10) == 0);
      cfgUseExtClk  = (($urandom % 4) == 0);
      cfgXtalBufOff = $urandom;
      cfgClkOutOff  = $urandom;
      cfgClkInOff   = $urandom;
      cfgAnalogOff  = (($urandom % 6) == 0);
      cfgDacOff     = N'($urandom);
      if (($urandom % 500) == 0) begin
        rstN = 0; #1; modelReset();
        compareAll();
        @(negedge clk); rstN = 1;
      end
      tick();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule